// File: doc/BRIEF.md
# Phase-Synchronized Triangular Carrier Timebase

This block produces the triangular carrier for one leg of a three-phase pulse-width modulator. A counter climbs from zero to a programmable period value, then falls back to zero, and repeats. One carrier cycle therefore lasts twice the period value in clock cycles. The outputs are the count, the present count direction, and one-cycle strobes at the zero and the period endpoints. Comparators and output stages further down the chain use these.

Three instances make up a three-phase set. The instance with phase loading turned off is the master and sends a sync pulse whenever its count is zero. The two slaves have phase loading turned on. A sync pulse arriving at a slave loads a programmed phase value and a programmed direction into its counter, and the slave passes the same pulse on to its own sync output. With a phase of two thirds of the period, and one slave resuming downward while the other resumes upward, the three carriers end up shifted against each other.

Period writes land in a shadow register. The shadow reaches the active period only at the zero of the count, so a write never cuts a ramp short.

Top module: `tri_carrier_timebase`

## Requirements
- R1: After reset the count is 0, the direction is up (`dir_up`=1), and both the active and the shadow period are 7030. Counting up with no sync and no write, the count therefore reaches 7030 on the 7030th clock after reset.
- R2: While the direction is up and the count is below the active period, each clock adds one to the count. When the count reaches the period value of the cycle it lands in, `dir_up` reads 0 in that same cycle.
- R3: While the direction is down, each clock subtracts one from the count. When the count reaches 0, `dir_up` reads 1, and the next clock gives a count of 1. Each endpoint lasts exactly one cycle, so with no sync and no write the carrier repeats every 2×period cycles.
- R4: A write on `prd_wr` changes only the shadow period. The shadow is copied into the active period on the clock edge that ends a cycle in which the count is 0. A write made partway through a ramp has no effect on that ramp's turning point.
- R5: `zero_evt` is 1 exactly in the cycles where the count is 0. `prd_evt` is 1 exactly in the cycles where the count equals the active period. With periods of 2 or more, the two are never high together.
- R6: With `phase_en`=0 (master), `sync_in` has no effect on the count or the direction, and `sync_out` is 1 exactly when the count is 0.
- R7: With `phase_en`=1 (slave), `sync_out` follows `sync_in` in the same cycle. A cycle with `sync_in`=1 gives, on the next clock, a count equal to `phase_val` and a direction equal to `phase_dir_up` (1 = up, 0 = down). This load takes priority over the normal count step.
- R8: If the count is at or above the active period while the direction is up, as happens after a phase load larger than the period, the next clock subtracts one and the direction becomes down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_en | input | 1 | 1 = slave (accepts sync and loads the phase), 0 = master |
| sync_in | input | 1 | Incoming sync pulse |
| phase_val | input | CNT_W | Count loaded on a sync pulse |
| phase_dir_up | input | 1 | Direction loaded on a sync pulse (1 = up) |
| prd_wr | input | 1 | Write strobe for the shadow period |
| prd_wdata | input | CNT_W | New period value |
| cnt | output | CNT_W | Carrier count |
| dir_up | output | 1 | 1 while counting up, 0 while counting down |
| zero_evt | output | 1 | Count equals zero |
| prd_evt | output | 1 | Count equals the active period |
| sync_out | output | 1 | Sync pulse sent to the next instance |

## Verification
A wrong counter step or a wrong direction shows on `cnt` on the very next clock. A corrupted direction flag shows as a ramp that overshoots or turns early. A stale or early-loaded active period stays hidden until the next turning point, which can be up to two periods later, so the bench follows every turn of a long default-period ramp and of many short random ones. A bad phase load shows one clock after the sync. A wrong master/slave route shows on `sync_out` in the same cycle.

// File: rtl/tcb_pkg.sv
// Package: shared types and defaults for the triangular carrier timebase.
// Assumes: one direction bit is enough to hold the count direction.
package tcb_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Default period: a 6.4 kHz symmetric carrier at the nominal clock.
    localparam int unsigned TCB_PRD_DEFAULT = 7030;
endpackage

// File: rtl/tcb_period_shadow.sv
// Module: tcb_period_shadow
// Holds the shadow and active period registers. A write goes to the shadow.
// The shadow is copied to the active period at the end of a cycle with a zero count.
// It also gives the period that is active in the next cycle, so the counter
// can flag its turning point early.
// Assumes: at_zero comes from the registered count.
module tcb_period_shadow #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PRD_RST = 7030
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             at_zero,
    output logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] prd_nxt
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(PRD_RST);

    logic [CNT_W-1:0] prd_shd;

    // Capture writes in the shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prd_shd <= RST_VAL;
        else if (wr)
            prd_shd <= wdata;
    end

    // Move the shadow into the active period only at a zero count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prd_act <= RST_VAL;
        else if (at_zero)
            prd_act <= prd_shd;
    end

    // Period that will be active in the next cycle.
    always_comb begin
        prd_nxt = at_zero ? prd_shd : prd_act;
    end
endmodule

// File: rtl/tcb_sync_route.sv
// Module: tcb_sync_route
// Chooses the sync output and the phase-load request for the instance role.
// Master: the sync output marks the zero count and sync_in is ignored.
// Slave: sync_in is passed straight through and requests a phase load.
// Assumes: phase_en is held steady while the carrier runs.
module tcb_sync_route (
    input  logic phase_en,
    input  logic sync_in,
    input  logic at_zero,
    output logic sync_out,
    output logic load
);
    // Route the sync by role.
    always_comb begin
        if (phase_en) begin
            sync_out = sync_in;
            load     = sync_in;
        end else begin
            sync_out = at_zero;
            load     = 1'b0;
        end
    end
endmodule

// File: rtl/tcb_counter.sv
// Module: tcb_counter
// Up-down counter with one cycle at each endpoint. A phase load wins over the step.
// The direction flag is worked out for the cycle the count lands in. It uses
// the period that will be active then, so dir reads down already at the peak.
// Assumes: period values of 2 or more.
module tcb_counter
    import tcb_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prd_act,
    input  logic [CNT_W-1:0] prd_nxt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_dir_up,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] cnt_nx;
    dir_e             dir_nx;

    // Take one step toward the current endpoint; turn back at or past it.
    always_comb begin
        if (dir == DIR_UP)
            stepped = (cnt < prd_act) ? cnt + ONE : cnt - ONE;
        else
            stepped = (cnt == '0) ? cnt + ONE : cnt - ONE;
    end

    // Pick the next count and direction; a phase load has priority.
    always_comb begin
        if (load) begin
            cnt_nx = load_val;
            dir_nx = load_dir_up ? DIR_UP : DIR_DOWN;
        end else begin
            cnt_nx = stepped;
            if (stepped == '0)
                dir_nx = DIR_UP;
            else if (stepped >= prd_nxt)
                dir_nx = DIR_DOWN;
            else
                dir_nx = (stepped > cnt) ? DIR_UP : DIR_DOWN;
        end
    end

    // Register the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else begin
            cnt <= cnt_nx;
            dir <= dir_nx;
        end
    end
endmodule

// File: rtl/tri_carrier_timebase.sv
// Module: tri_carrier_timebase
// Triangular carrier timebase for one leg of a three-phase modulator.
// It joins the period shadow, the sync routing and the counter, and decodes
// the endpoint strobes from the registered state.
// Assumes: synchronous active-low reset; periods of 2 or more.
module tri_carrier_timebase
    import tcb_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PRD_RST = TCB_PRD_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_en,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] phase_val,
    input  logic             phase_dir_up,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             sync_out
);
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] prd_nxt;
    logic             load;
    dir_e             dir;

    tcb_period_shadow #(
        .CNT_W  (CNT_W),
        .PRD_RST(PRD_RST)
    ) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (prd_wr),
        .wdata  (prd_wdata),
        .at_zero(zero_evt),
        .prd_act(prd_act),
        .prd_nxt(prd_nxt)
    );

    tcb_sync_route u_route (
        .phase_en(phase_en),
        .sync_in (sync_in),
        .at_zero (zero_evt),
        .sync_out(sync_out),
        .load    (load)
    );

    tcb_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .prd_act    (prd_act),
        .prd_nxt    (prd_nxt),
        .load       (load),
        .load_val   (phase_val),
        .load_dir_up(phase_dir_up),
        .cnt        (cnt),
        .dir        (dir)
    );

    // Decode the endpoint strobes and the direction bit.
    always_comb begin
        zero_evt = (cnt == '0);
        prd_evt  = (cnt == prd_act);
        dir_up   = (dir == DIR_UP);
    end
endmodule

// File: rtl/tri_carrier_timebase_chk.sv
// Module: tri_carrier_timebase_chk
// Checker for the timebase. It watches the top-level ports and the active period.
// Assumes: the bench writes only periods of 2 or more.
module tri_carrier_timebase_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_en,
    input logic             sync_in,
    input logic [CNT_W-1:0] phase_val,
    input logic             phase_dir_up,
    input logic [CNT_W-1:0] cnt,
    input logic             dir_up,
    input logic             zero_evt,
    input logic             prd_evt,
    input logic             sync_out,
    input logic [CNT_W-1:0] prd_act
);
    logic slave_load;
    assign slave_load = phase_en && sync_in;

    // R2 R3: with no load, the count moves by exactly one each clock.
    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_load |=> (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
                         ({1'b0, cnt} + 1'b1 == {1'b0, $past(cnt)})));

    // R3: leaving zero goes up to one.
    assert_zero_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !slave_load) |=> (dir_up && cnt == CNT_W'(1)));

    // R2: at the period endpoint the direction already reads down.
    assert_peak_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_evt && !$past(slave_load)) |-> !dir_up);

    // R4: the active period changes only after a zero count.
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (prd_act == $past(prd_act)));

    // R5: both endpoint strobes are never high together.
    assert_events_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_evt && prd_evt));

    // R6: a master sends a sync only at a zero count.
    assert_master_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_en && sync_out) |-> (cnt == '0));

    // R7: a slave sync loads the phase value and the direction.
    assert_phase_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slave_load |=> (cnt == $past(phase_val) && dir_up == $past(phase_dir_up)));

    // R7: a slave passes the sync through.
    assert_slave_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en |-> (sync_out == sync_in));
endmodule

bind tri_carrier_timebase tri_carrier_timebase_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_en    (phase_en),
    .sync_in     (sync_in),
    .phase_val   (phase_val),
    .phase_dir_up(phase_dir_up),
    .cnt         (cnt),
    .dir_up      (dir_up),
    .zero_evt    (zero_evt),
    .prd_evt     (prd_evt),
    .sync_out    (sync_out),
    .prd_act     (prd_act)
);

// File: tb/tri_carrier_timebase_bench.sv
`timescale 1ns/1ps
// Bench for tri_carrier_timebase. It runs directed corner cases, then seeded
// random segments, against a reference model written from the requirements.
module tri_carrier_timebase_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             phase_en = 1'b0;
    logic             sync_in = 1'b0;
    logic [CNT_W-1:0] phase_val = '0;
    logic             phase_dir_up = 1'b0;
    logic             prd_wr = 1'b0;
    logic [CNT_W-1:0] prd_wdata = '0;
    logic [CNT_W-1:0] cnt;
    logic             dir_up;
    logic             zero_evt;
    logic             prd_evt;
    logic             sync_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model state.
    int    m_cnt, m_act, m_shd;
    bit    m_dir;
    string m_tag;

    tri_carrier_timebase u_tri_carrier_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_en    (phase_en),
        .sync_in     (sync_in),
        .phase_val   (phase_val),
        .phase_dir_up(phase_dir_up),
        .prd_wr      (prd_wr),
        .prd_wdata   (prd_wdata),
        .cnt         (cnt),
        .dir_up      (dir_up),
        .zero_evt    (zero_evt),
        .prd_evt     (prd_evt),
        .sync_out    (sync_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Next direction from the requirements: zero means up, at or past the next period means down.
    function automatic bit ref_dir(input int c, input int prev, input int pnext);
        if (c == 0) return 1'b1;
        if (c >= pnext) return 1'b0;
        return (c > prev);
    endfunction

    // Compare the registered outputs against the model.
    task automatic compare_state();
        check(int'(cnt) == m_cnt, m_tag, "cnt", int'(cnt), m_cnt);
        check(dir_up == m_dir, m_tag, "dir_up", int'(dir_up), int'(m_dir));
        check(zero_evt == (m_cnt == 0), "R5", "zero_evt", int'(zero_evt), int'(m_cnt == 0));
        check(prd_evt == (m_cnt == m_act), "R5", "prd_evt", int'(prd_evt), int'(m_cnt == m_act));
    endtask

    // Apply one cycle of inputs at the falling edge, advance the model, compare at the next falling edge.
    task automatic tick(input bit pe, input bit si, input int pv, input bit pd,
                        input bit wr, input int wd);
        int  pnext, c;
        bit  d;
        phase_en = pe; sync_in = si; phase_val = CNT_W'(pv);
        phase_dir_up = pd; prd_wr = wr; prd_wdata = CNT_W'(wd);
        #1;
        if (pe) check(sync_out == si, "R7", "sync_out", int'(sync_out), int'(si));
        else    check(sync_out == (m_cnt == 0), "R6", "sync_out", int'(sync_out), int'(m_cnt == 0));
        pnext = (m_cnt == 0) ? m_shd : m_act;
        if (pe && si) begin
            c = pv; d = pd; m_tag = "R7";
        end else begin
            if (m_dir) begin
                if (m_cnt < m_act) begin c = m_cnt + 1; m_tag = "R2"; end
                else begin c = m_cnt - 1; m_tag = "R8"; end
            end else begin
                if (m_cnt == 0) c = 1; else c = m_cnt - 1;
                m_tag = "R3";
            end
            if (!pe && si) m_tag = "R6";
            d = ref_dir(c, m_cnt, pnext);
        end
        if (m_cnt == 0) m_act = m_shd;
        if (wr) m_shd = wd;
        m_cnt = c; m_dir = d;
        @(negedge clk);
        compare_state();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5ns * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = 0; m_dir = 1'b1; m_act = 7030; m_shd = 7030; m_tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check(cnt == '0, "R1", "reset cnt", int'(cnt), 0);
        check(dir_up == 1'b1, "R1", "reset dir_up", int'(dir_up), 1);
        check(zero_evt == 1'b1, "R1", "reset zero_evt", int'(zero_evt), 1);
        check(prd_evt == 1'b0, "R1", "reset prd_evt", int'(prd_evt), 0);

        // R1: the default period turns the ramp at 7030.
        idle(7030);
        check(int'(cnt) == 7030, "R1", "peak cnt", int'(cnt), 7030);
        check(prd_evt && !dir_up, "R1", "peak strobe and direction", int'({prd_evt, dir_up}), 2);

        // R4: a write during the down ramp leaves it alone until zero.
        tick(1'b0, 1'b0, 0, 1'b0, 1'b1, 20);
        idle(100);
        check(int'(cnt) == 6929 && !dir_up, "R4", "down ramp after write", int'(cnt), 6929);
        idle(6929);
        check(int'(cnt) == 0 && dir_up, "R3", "reached zero", int'(cnt), 0);
        idle(20);
        check(int'(cnt) == 20 && prd_evt && !dir_up, "R4", "new peak", int'(cnt), 20);
        idle(1);
        check(int'(cnt) == 19, "R4", "after new peak", int'(cnt), 19);

        // R6: master ignores a held sync.
        for (int i = 0; i < 30; i++) tick(1'b0, 1'b1, 55, 1'b1, 1'b0, 0);

        // R7 R8: slave load above the period, resuming up.
        tick(1'b1, 1'b1, 45, 1'b1, 1'b0, 0);
        check(int'(cnt) == 45 && dir_up, "R7", "phase load", int'(cnt), 45);
        idle(1);
        check(int'(cnt) == 44 && !dir_up, "R8", "above period turns down", int'(cnt), 44);

        // Random segments.
        for (int s = 0; s < 60; s++) begin
            bit pe  = 1'($urandom % 2);
            int pv  = int'($urandom % 61);
            bit pd  = 1'($urandom % 2);
            for (int i = 0; i < 1400; i++) begin
                bit si = ($urandom % 40) == 0;
                bit wr = ($urandom % 200) == 0;
                int wd = 2 + int'($urandom % 39);
                tick(pe, si, pv, pd, wr, wd);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule